// File: doc/BRIEF.md
# Packet Network I/O Register Front End

This block sits between an 8-bit CPU I/O bus and a byte-wide packet network core. It claims an eight-byte window of I/O space, keeps the host-visible status, control and configuration state, and returns read data for the addressed offset. The core's receive and transmit buffers sit behind two data offsets. Each read of the receive offset pops one byte from the receive buffer. Each write to the transmit offset pushes one byte into the transmit buffer.

The core reports events with single-cycle pulses: a packet has arrived, or a transmission has finished. The block holds these events as sticky status bits until the host clears them. Writing the control offset launches a transmission with a one-clock start pulse. A configuration bit drives a level that tells the core to generate and check the preamble and start-of-frame delimiter (0xD5).

Top module: `pkt_io_regs`

## Requirements
- R1: An access is claimed only when address bits [7:3] equal bits [7:3] of the base address (default 0xA0). An access outside the window has no effect, gives no strobe, and reads as 0x00. The offset is address bits [2:0].
- R2: A synchronous active-high reset clears the status bits, the start pulse and the configuration bit. After reset, `tx_start`, `preamble_en` and the status reading are all 0.
- R3: Reading offset 0 returns {6'b0, tx_done, rx_ready}: bit 0 means a received packet is ready and bit 1 means a transmission has completed. Each bit is set by its event pulse (`evt_rx_ready`, `evt_tx_done`) at the next clock edge and stays set until cleared.
- R4: Writing offset 0 with a 1 in bit 0 or bit 1 clears that status bit. If an event pulse and a clear for the same bit arrive in the same cycle, the bit stays set.
- R5: Writing offset 1 with bit 0 = 1 raises `tx_start` for exactly one clock, starting with the edge after the write. A write while the pulse is high is ignored. Offset 1 reads {7'b0, pulse}. A write with bit 0 = 0 gives no pulse.
- R6: Writing offset 6 stores bit 0, which drives `preamble_en` as a level from the next edge. Offset 6 reads {7'b0, stored bit}.
- R7: Offset 2 reads `rx_len[7:0]` and offset 3 reads `rx_len[15:8]`.
- R8: A read of offset 4 returns `rx_byte` in the same cycle and raises `rx_pop` for that cycle only.
- R9: A write to offset 5 raises `tx_push` for that cycle, with `tx_push_data` equal to the written byte.
- R10: Offset 7 reads 0x00. Reads of offset 5 and writes to offsets 2, 3, 4 and 7 change no state and give no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | I/O address |
| bus_rd | input | 1 | Read request, one cycle per access |
| bus_wr | input | 1 | Write request, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| evt_rx_ready | input | 1 | Core pulse: packet received |
| evt_tx_done | input | 1 | Core pulse: transmission finished |
| rx_len | input | 16 | Received packet length |
| rx_byte | input | 8 | Current receive buffer byte |
| rx_pop | output | 1 | Advance receive read pointer |
| tx_push | output | 1 | Store byte in transmit buffer |
| tx_push_data | output | 8 | Byte to store |
| tx_start | output | 1 | One-clock transmit request |
| preamble_en | output | 1 | Preamble/delimiter enable level |

## Verification
Read data and the pop/push strobes are combinational, so the bench samples them 1 time unit after it drives an access, in the same cycle. Status, the start pulse and the preamble level are registered. Each of them is checked at the falling edge that follows the edge capturing the stimulus, so a result is due exactly one edge after its cause. The bench model steps its expected state at the same point, so an event pulse and a clear in the same cycle resolve in the same order as the requirements state.

// File: rtl/pkt_io_pkg.sv
package pkt_io_pkg;
    localparam int BYTE_W = 8;
    localparam int OFF_W  = 3;
    localparam int N_EVT  = 2;

    typedef enum logic [OFF_W-1:0] {
        OFF_STAT = 3'd0,
        OFF_CTRL = 3'd1,
        OFF_LENL = 3'd2,
        OFF_LENH = 3'd3,
        OFF_RXD  = 3'd4,
        OFF_TXD  = 3'd5,
        OFF_CFG  = 3'd6,
        OFF_RSVD = 3'd7
    } reg_off_e;

    typedef struct packed {
        logic     hit;
        logic     rd;
        logic     wr;
        reg_off_e off;
    } access_t;

    function automatic logic is_wr(access_t a, reg_off_e o);
        return a.hit && a.wr && (a.off == o);
    endfunction

    function automatic logic is_rd(access_t a, reg_off_e o);
        return a.hit && a.rd && (a.off == o);
    endfunction
endpackage

// File: rtl/pkt_io_decode.sv
module pkt_io_decode
    import pkt_io_pkg::*;
#(
    parameter int              ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE = 8'hA0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output access_t           acc
);
    localparam int TAG_W = ADDR_W - OFF_W;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:OFF_W];

    always_comb begin
        acc.hit = (addr[ADDR_W-1:OFF_W] == BASE_TAG);
        acc.rd  = rd;
        acc.wr  = wr;
        acc.off = reg_off_e'(addr[OFF_W-1:0]);
    end
endmodule

// File: rtl/pkt_io_status.sv
module pkt_io_status
    import pkt_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [N_EVT-1:0]  evt,
    output logic [N_EVT-1:0]  stat
);
    logic clr_en;
    assign clr_en = is_wr(acc, OFF_STAT);

    for (genvar g = 0; g < N_EVT; g++) begin : g_bit
        logic clr;
        assign clr = clr_en && wdata[g];

        always_ff @(posedge clk) begin
            if (rst)         stat[g] <= 1'b0;
            else if (evt[g]) stat[g] <= 1'b1;
            else if (clr)    stat[g] <= 1'b0;
        end

        // R3
        sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
            evt[g] |=> stat[g]);
        // R4
        hold_unless_clr_chk: assert property (@(posedge clk) disable iff (rst)
            (stat[g] && !clr) |=> stat[g]);
    end
endmodule

// File: rtl/pkt_io_ctrl.sv
module pkt_io_ctrl
    import pkt_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic [BYTE_W-1:0] wdata,
    output logic              go,
    output logic              cfg_pre
);
    always_ff @(posedge clk) begin
        if (rst) begin
            go      <= 1'b0;
            cfg_pre <= 1'b0;
        end else begin
            go <= is_wr(acc, OFF_CTRL) && wdata[0] && !go;
            if (is_wr(acc, OFF_CFG))
                cfg_pre <= wdata[0];
        end
    end

    // R5
    one_clock_go_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> !go);
    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !is_wr(acc, OFF_CFG) |=> $stable(cfg_pre));
endmodule

// File: rtl/pkt_io_rdmux.sv
module pkt_io_rdmux
    import pkt_io_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  access_t           acc,
    input  logic [N_EVT-1:0]  stat,
    input  logic              go,
    input  logic              cfg_pre,
    input  logic [LEN_W-1:0]  len,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BYTE_W-1:0] rdata
);
    localparam int LEN_PAD = 2 * BYTE_W;
    logic [LEN_PAD-1:0] len_ext;
    assign len_ext = LEN_PAD'(len);

    always_comb begin
        rdata = '0;
        if (acc.hit && acc.rd) begin
            unique case (acc.off)
                OFF_STAT: rdata = BYTE_W'(stat);
                OFF_CTRL: rdata = BYTE_W'(go);
                OFF_LENL: rdata = len_ext[BYTE_W-1:0];
                OFF_LENH: rdata = len_ext[2*BYTE_W-1:BYTE_W];
                OFF_RXD:  rdata = rx_byte;
                OFF_CFG:  rdata = BYTE_W'(cfg_pre);
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pkt_io_regs.sv
module pkt_io_regs
    import pkt_io_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter logic [7:0]  BASE   = 8'hA0,
    parameter int          LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              evt_rx_ready,
    input  logic              evt_tx_done,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_pop,
    output logic              tx_push,
    output logic [BYTE_W-1:0] tx_push_data,
    output logic              tx_start,
    output logic              preamble_en
);
    access_t            acc;
    logic [N_EVT-1:0]   stat;
    logic               go;
    logic               cfg_pre;

    pkt_io_decode #(.ADDR_W(ADDR_W), .BASE(ADDR_W'(BASE))) i_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .acc(acc));

    pkt_io_status i_stat (
        .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata),
        .evt({evt_tx_done, evt_rx_ready}), .stat(stat));

    pkt_io_ctrl i_ctrl (
        .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata),
        .go(go), .cfg_pre(cfg_pre));

    pkt_io_rdmux #(.LEN_W(LEN_W)) i_mux (
        .acc(acc), .stat(stat), .go(go), .cfg_pre(cfg_pre),
        .len(rx_len), .rx_byte(rx_byte), .rdata(bus_rdata));

    assign rx_pop       = is_rd(acc, OFF_RXD);
    assign tx_push      = is_wr(acc, OFF_TXD);
    assign tx_push_data = bus_wdata;
    assign tx_start     = go;
    assign preamble_en  = cfg_pre;

    // R1
    outside_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[ADDR_W-1:OFF_W] != BASE[7:OFF_W]) |->
            (bus_rdata == '0 && !rx_pop && !tx_push));
    // R8
    pop_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (bus_rd && bus_rdata == rx_byte));
    // R9
    push_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> (bus_wr && tx_push_data == bus_wdata));
endmodule

// File: tb/test_pkt_io_regs.sv
module test_pkt_io_regs;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        evt_rx_ready = 1'b0, evt_tx_done = 1'b0;
    logic [15:0] rx_len = 16'h0000;
    logic [7:0]  rx_byte;
    logic        rx_pop, tx_push, tx_start, preamble_en;
    logic [7:0]  tx_push_data;

    int total = 0, bad = 0;
    int pops = 0, pushes = 0, starts = 0;
    bit done = 0;

    // behavioural core: receive buffer contents as a function of pop count
    function automatic logic [7:0] rx_mem(int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction
    assign rx_byte = rx_mem(pops);

    always #(CLK_T/2) clk = ~clk;
    always @(posedge clk) begin
        if (rx_pop)  pops++;
        if (tx_push) pushes++;
    end
    always @(negedge clk) if (tx_start) starts++;

    pkt_io_regs i_pkt_io_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_rx_ready(evt_rx_ready), .evt_tx_done(evt_tx_done),
        .rx_len(rx_len), .rx_byte(rx_byte), .rx_pop(rx_pop),
        .tx_push(tx_push), .tx_push_data(tx_push_data),
        .tx_start(tx_start), .preamble_en(preamble_en));

    // bench model state
    logic [1:0] m_stat = '0;
    logic       m_go = 0, m_cfg = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic in_win(logic [7:0] a);
        return a[7:3] == 5'b10100;
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        if (!in_win(a)) return 8'h00;
        case (a[2:0])
            3'd0: return {6'b0, m_stat};
            3'd1: return {7'b0, m_go};
            3'd2: return rx_len[7:0];
            3'd3: return rx_len[15:8];
            3'd4: return rx_byte;
            3'd6: return {7'b0, m_cfg};
            default: return 8'h00;
        endcase
    endfunction

    // one bus cycle: drive at negedge, check comb outputs, step model
    task automatic cycle(string req, logic [7:0] a, logic r, logic w,
                         logic [7:0] d, logic er, logic et);
        logic [1:0] clr;
        @(negedge clk);
        chk("R5 tx_start", tx_start, m_go);
        chk("R6 preamble_en", preamble_en, m_cfg);
        bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
        evt_rx_ready = er; evt_tx_done = et;
        #1;
        if (r) chk({req, " rdata"}, bus_rdata, exp_rd(a));
        chk("R8 rx_pop", rx_pop, r && in_win(a) && a[2:0] == 3'd4);
        chk("R9 tx_push", tx_push, w && in_win(a) && a[2:0] == 3'd5);
        if (tx_push) chk("R9 push data", tx_push_data, d);
        clr = (w && in_win(a) && a[2:0] == 3'd0) ? d[1:0] : 2'b00;
        m_stat = (m_stat & ~clr) | {et, er};
        m_go   = w && in_win(a) && a[2:0] == 3'd1 && d[0] && !m_go;
        if (w && in_win(a) && a[2:0] == 3'd6) m_cfg = d[0];
    endtask

    task automatic idle();
        cycle("idle", 8'h00, 0, 0, 8'h00, 0, 0);
    endtask

    initial begin
        #(CLK_T * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int p0, s0, u0;
        void'($urandom(32'd1234));
        rx_len = 16'h1A7C;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R2 reset state
        chk("R2 tx_start", tx_start, 0);
        chk("R2 preamble_en", preamble_en, 0);
        cycle("R2 status", 8'hA0, 1, 0, 0, 0, 0);
        // R7 length bytes
        cycle("R7 low", 8'hA2, 1, 0, 0, 0, 0);
        cycle("R7 high", 8'hA3, 1, 0, 0, 0, 0);
        // R8 pop sequence
        p0 = pops;
        for (int i = 0; i < 3; i++) cycle("R8 rxd", 8'hA4, 1, 0, 0, 0, 0);
        idle();
        chk("R8 pop count", pops - p0, 3);
        // R9 push
        u0 = pushes;
        cycle("R9 txd", 8'hA5, 0, 1, 8'h3C, 0, 0);
        idle();
        chk("R9 push count", pushes - u0, 1);
        // R10 offset 7, read of 5, writes to read-only offsets
        cycle("R10 off7", 8'hA7, 1, 0, 0, 0, 0);
        p0 = pops; u0 = pushes;
        cycle("R10 rd5", 8'hA5, 1, 0, 0, 0, 0);
        cycle("R10 wr4", 8'hA4, 0, 1, 8'hFF, 0, 0);
        cycle("R10 wr7", 8'hA7, 0, 1, 8'hFF, 0, 0);
        idle();
        chk("R10 no strobes", (pops - p0) + (pushes - u0), 0);
        // R1 outside window
        cycle("R1 outside rd", 8'hA8, 1, 0, 0, 0, 0);
        cycle("R1 outside wr", 8'h21, 0, 1, 8'h01, 0, 0);
        cycle("R1 outside cfg", 8'hB6, 0, 1, 8'h01, 0, 0);
        idle();
        chk("R1 no start", tx_start, 0);
        // R5 start pulse width, back-to-back write ignored
        s0 = starts;
        cycle("R5 go", 8'hA1, 0, 1, 8'h01, 0, 0);
        cycle("R5 readback", 8'hA1, 1, 0, 0, 0, 0);
        idle(); idle();
        chk("R5 pulse width", starts - s0, 1);
        s0 = starts;
        cycle("R5 go a", 8'hA1, 0, 1, 8'h01, 0, 0);
        cycle("R5 go b", 8'hA1, 0, 1, 8'h01, 0, 0);
        idle(); idle();
        chk("R5 ignored while high", starts - s0, 1);
        // R3 / R4 set, clear, priority
        cycle("R3 set rx", 8'h00, 0, 0, 0, 1, 0);
        cycle("R3 read", 8'hA0, 1, 0, 0, 0, 1);
        cycle("R3 both", 8'hA0, 1, 0, 0, 0, 0);
        cycle("R4 clr rx prio", 8'hA0, 0, 1, 8'h03, 1, 0);
        cycle("R4 read", 8'hA0, 1, 0, 0, 0, 0);
        cycle("R4 clr all", 8'hA0, 0, 1, 8'h03, 0, 0);
        cycle("R4 read zero", 8'hA0, 1, 0, 0, 0, 0);
        // R6 config
        cycle("R6 set", 8'hA6, 0, 1, 8'hFF, 0, 0);
        cycle("R6 read", 8'hA6, 1, 0, 0, 0, 0);
        // constrained random
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a;
            int op;
            a  = ($urandom % 8 != 0) ? {5'b10100, 3'($urandom)} : 8'($urandom);
            op = $urandom % 3;
            if ($urandom % 16 == 0) rx_len = 16'($urandom);
            cycle("R3 random", a, op == 0, op == 1, 8'($urandom),
                  ($urandom % 6) == 0, ($urandom % 6) == 0);
        end
        idle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule